// File: doc/BRIEF.md
# Operand Unpack Unit

This block sits between a register read port and an ALU operand input. It takes one 32-bit operand word and reshapes it according to a 3-bit unpack selector. The selector can leave the word alone, copy its top byte into every byte position, pick one 16-bit half, or pick one 8-bit lane. A float-select input tells the unit how the consuming instruction reads a narrow field. When it is high, a half is read as an IEEE half-precision value and a byte lane as a normalized colour value in [0,1], and either is widened to single precision. When it is low, the field is widened as an integer.

The conversion logic is purely combinational. A parameter, `OUT_REG`, adds one output register stage, which gives the unit one cycle of latency from operand to result. With `OUT_REG` = 0 the result follows the inputs in the same cycle. Internally the selector is decoded into one of four unpack kinds: `KIND_PASS` (selector 0), `KIND_HALF` (selectors 1 and 2), `KIND_REPL` (selector 3) and `KIND_BYTE` (selectors 4 to 7). Each kind steers one conversion path to the output. There are no sequential states beyond the optional output stage.

Top module: `opnd_unpack`

## Requirements
- R1: With `OUT_REG` = 1, `res_word` is 0 while `rst_n` is low. After reset, the result for the inputs present at a rising clock edge appears on `res_word` just after that edge, so latency is exactly one cycle.
- R2: Selector 0 returns the operand unchanged, whatever the value of `as_float`.
- R3: Selector 3 returns operand bits 31:24 copied into all four byte positions of the result, whatever the value of `as_float`.
- R4: Selector 1 takes operand bits 15:0 and selector 2 takes operand bits 31:16. With `as_float` low, the chosen half is sign-extended to 32 bits.
- R5: With `as_float` high, a normal half-precision value (sign bit 15, exponent bits 14:10 with bias 15, fraction bits 9:0) is converted exactly to single precision (sign bit 31, exponent bits 30:23 with bias 127, fraction bits 22:0).
- R6: With `as_float` high, half zeros keep their sign. Half infinities become single infinities of the same sign. A half NaN becomes a single NaN with the same sign and its 10-bit fraction placed in bits 22:13.
- R7: With `as_float` high, a subnormal half (exponent field 0, fraction nonzero) is converted to the exactly equal normal single-precision value.
- R8: Selectors 4, 5, 6 and 7 take operand bits 7:0, 15:8, 23:16 and 31:24 respectively. With `as_float` low, the byte is zero-extended to 32 bits.
- R9: With `as_float` high, a selected byte b becomes the single-precision value nearest to b/255, with ties rounding to even. Byte 0 gives exactly 0x00000000 and byte 255 gives exactly 0x3F800000 (1.0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| src_word | input | 32 | Operand word as read from the register file or accumulator |
| unpk_sel | input | 3 | Unpack selector, values 0 to 7 as in R2 to R9 |
| as_float | input | 1 | High: widen narrow fields as floating point; low: as integers |
| res_word | output | 32 | Unpacked operand handed to the ALU input |

## Verification
Two things meet in the same cycle here. The output register is presenting the previous operand's converted value while the conversion paths are already evaluating a new operand under a different selector or float setting. The bench provokes this with back-to-back operands, one per cycle, that alternate the selector and flip `as_float` on the same word. It also sweeps all 256 byte values through two lanes in consecutive cycles. A scoreboard queue holds the expected word for each operand in issue order and compares it one cycle later. Any result that leaks between neighbouring operands, or any mode decode that is delayed or early, therefore shows up as a mismatch.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 3;
    localparam int LANES   = WORD_W / BYTE_W;

    // half-precision layout
    localparam int H_EXP_W = 5;
    localparam int H_MAN_W = 10;
    localparam int H_BIAS  = 15;

    // single-precision layout
    localparam int S_EXP_W = 8;
    localparam int S_MAN_W = 23;
    localparam int S_BIAS  = 127;

    localparam int MAN_GAP = S_MAN_W - H_MAN_W;     // 13
    localparam int REBIAS  = S_BIAS - H_BIAS;       // 112
    localparam int SUB_OFS = S_BIAS - H_BIAS - H_MAN_W + 1 - 1; // 102 + 1 adjust below

    localparam logic [WORD_W-1:0] ONE_SGL = 32'h3F80_0000;

    typedef enum logic [1:0] {
        KIND_PASS = 2'd0,
        KIND_HALF = 2'd1,
        KIND_REPL = 2'd2,
        KIND_BYTE = 2'd3
    } unpk_kind_e;

endpackage

// File: rtl/unpk_field_sel.sv
module unpk_field_sel
    import unpk_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output unpk_kind_e        kind_o,
    output logic [HALF_W-1:0] half_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [WORD_W-1:0] repl_o
);

    logic [BYTE_W-1:0] lane [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        unique case (sel_i)
            3'd0:                kind_o = KIND_PASS;
            3'd1, 3'd2:          kind_o = KIND_HALF;
            3'd3:                kind_o = KIND_REPL;
            default:             kind_o = KIND_BYTE;
        endcase
    end

    always_comb begin
        half_o = sel_i[1] ? word_i[WORD_W-1 -: HALF_W] : word_i[HALF_W-1:0];
        byte_o = lane[sel_i[1:0]];
        repl_o = {LANES{lane[LANES-1]}};
    end

endmodule

// File: rtl/unpk_half_cvt.sv
module unpk_half_cvt
    import unpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_i,
    input  logic              as_float_i,
    output logic [WORD_W-1:0] word_o
);

    logic                 sgn;
    logic [H_EXP_W-1:0]   hexp;
    logic [H_MAN_W-1:0]   hman;
    logic [3:0]           lead;
    logic [H_MAN_W:0]     norm_man;
    logic [S_EXP_W-1:0]   sub_exp;
    logic [S_EXP_W-1:0]   nrm_exp;

    always_comb begin
        sgn  = half_i[HALF_W-1];
        hexp = half_i[HALF_W-2 -: H_EXP_W];
        hman = half_i[H_MAN_W-1:0];

        lead = 4'd0;
        for (int i = 0; i < H_MAN_W; i++) begin
            if (hman[i]) lead = 4'(i);
        end
        // move the leading one to the hidden-bit position
        norm_man = {1'b0, hman} << (4'(H_MAN_W) - lead);
        // value = 2^(lead-24) * 1.f  ->  biased exponent lead + 103
        sub_exp  = 8'(lead) + 8'(S_BIAS - 24);
        nrm_exp  = 8'(hexp) + 8'(REBIAS);
    end

    always_comb begin
        if (!as_float_i) begin
            word_o = {{(WORD_W-HALF_W){sgn}}, half_i};
        end else if (hexp == '1) begin
            word_o = {sgn, {S_EXP_W{1'b1}}, hman, {MAN_GAP{1'b0}}};
        end else if (hexp == '0) begin
            if (hman == '0) begin
                word_o = {sgn, {(WORD_W-1){1'b0}}};
            end else begin
                word_o = {sgn, sub_exp, norm_man[H_MAN_W-1:0], {MAN_GAP{1'b0}}};
            end
        end else begin
            word_o = {sgn, nrm_exp, hman, {MAN_GAP{1'b0}}};
        end
    end

    // integer widening copies the half's sign into the whole upper half
    assert_half_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !as_float_i |-> (word_o[WORD_W-1:HALF_W] == {HALF_W{half_i[HALF_W-1]}}));

    // specials stay specials and keep their sign
    assert_half_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (as_float_i && half_i[HALF_W-2 -: H_EXP_W] == '1) |->
        (word_o[30:23] == 8'hFF && word_o[31] == half_i[15]));

    // any nonzero finite half maps to a normal single
    assert_half_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (as_float_i && half_i[14:10] != 5'h1F && half_i[14:0] != 15'h0) |->
        (word_o[30:23] != 8'h00 && word_o[30:23] != 8'hFF));

endmodule

// File: rtl/unpk_byte_cvt.sv
module unpk_byte_cvt
    import unpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              as_float_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int PAT_W = 6 * BYTE_W;   // enough repeats for 24 bits + guard + sticky period
    localparam int SIG_W = S_MAN_W + 1;

    logic [2:0]         lz;
    logic [PAT_W-1:0]   pat;
    logic [PAT_W-1:0]   shifted;
    logic [SIG_W-1:0]   sig;
    logic               guard;
    logic               sticky;
    logic               bump;
    logic [SIG_W:0]     rounded;
    logic [S_EXP_W-1:0] bexp;
    logic [WORD_W-1:0]  flt_word;

    // b/255 in binary is the byte repeated forever after the point
    always_comb begin
        lz = 3'd0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (byte_i[i]) lz = 3'(BYTE_W - 1 - i);
        end
        pat     = {6{byte_i}};
        shifted = pat << lz;
        sig     = shifted[PAT_W-1 -: SIG_W];
        guard   = shifted[PAT_W-1-SIG_W];
        sticky  = |shifted[PAT_W-2-SIG_W:0];
        bump    = guard & (sticky | sig[0]);
        rounded = {1'b0, sig} + (SIG_W+1)'(bump);
        bexp    = 8'(S_BIAS - 1) - 8'(lz) + 8'(rounded[SIG_W]);
        if (byte_i == '0) begin
            flt_word = '0;
        end else if (rounded[SIG_W]) begin
            flt_word = {1'b0, bexp, {S_MAN_W{1'b0}}};
        end else begin
            flt_word = {1'b0, bexp, rounded[S_MAN_W-1:0]};
        end
    end

    always_comb begin
        word_o = as_float_i ? flt_word : {{(WORD_W-BYTE_W){1'b0}}, byte_i};
    end

    assert_byte_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !as_float_i |-> (word_o[WORD_W-1:BYTE_W] == '0 && word_o[BYTE_W-1:0] == byte_i));

    assert_byte_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        as_float_i |-> (word_o <= ONE_SGL));

    assert_byte_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (as_float_i && byte_i == 8'hFF) |-> (word_o == ONE_SGL));

endmodule

// File: rtl/opnd_unpack.sv
module opnd_unpack
    import unpk_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_word,
    input  logic [2:0]        unpk_sel,
    input  logic              as_float,
    output logic [31:0]       res_word
);

    unpk_kind_e        kind;
    logic [HALF_W-1:0] half_fld;
    logic [BYTE_W-1:0] byte_fld;
    logic [WORD_W-1:0] repl_word;
    logic [WORD_W-1:0] half_word;
    logic [WORD_W-1:0] byte_word;
    logic [WORD_W-1:0] nxt_word;
    logic              primed;

    unpk_field_sel u_sel (
        .word_i (src_word),
        .sel_i  (unpk_sel),
        .kind_o (kind),
        .half_o (half_fld),
        .byte_o (byte_fld),
        .repl_o (repl_word)
    );

    unpk_half_cvt u_half (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_i     (half_fld),
        .as_float_i (as_float),
        .word_o     (half_word)
    );

    unpk_byte_cvt u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (byte_fld),
        .as_float_i (as_float),
        .word_o     (byte_word)
    );

    always_comb begin
        unique case (kind)
            KIND_PASS: nxt_word = src_word;
            KIND_HALF: nxt_word = half_word;
            KIND_REPL: nxt_word = repl_word;
            KIND_BYTE: nxt_word = byte_word;
            default:   nxt_word = src_word;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_word <= '0;
                else        res_word <= nxt_word;
            end
        end else begin : g_comb
            assign res_word = nxt_word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (unpk_sel == 3'd0) |-> (nxt_word == src_word));

    assert_repl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unpk_sel == 3'd3) |-> (nxt_word[7:0] == src_word[31:24] &&
                                nxt_word[15:8] == src_word[31:24] &&
                                nxt_word[23:16] == src_word[31:24] &&
                                nxt_word[31:24] == src_word[31:24]));

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && primed) |-> (res_word == $past(nxt_word)));

endmodule

// File: tb/sim_opnd_unpack.sv
`timescale 1ns/1ps
module sim_opnd_unpack;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_word = '0;
    logic [2:0]  unpk_sel = '0;
    logic        as_float = 1'b0;
    logic [31:0] res_word;

    int     n_checks = 0;
    int     n_errors = 0;
    item_t  sb[$];
    bit     done = 1'b0;

    always #2.5 clk = ~clk;

    opnd_unpack #(.OUT_REG(1'b1)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_word (src_word),
        .unpk_sel (unpk_sel),
        .as_float (as_float),
        .res_word (res_word)
    );

    function automatic logic [31:0] to_sgl(real v);
        logic [63:0] b;
        int          se;
        logic [22:0] keep;
        logic        up;
        b    = $realtobits(v);
        se   = int'(b[62:52]) - 1023 + 127;
        keep = b[51:29];
        up   = b[28] & ((|b[27:0]) | keep[0]);
        return {1'b0, se[7:0], keep} + 32'(up);
    endfunction

    function automatic logic [31:0] half_ref(logic [15:0] h);
        logic [31:0] r;
        int e;
        real v;
        e = int'(h[14:10]);
        if (e == 31) return {h[15], 8'hFF, h[9:0], 13'h0};
        if (e == 0 && h[9:0] == 0) return {h[15], 31'h0};
        if (e == 0) v = real'(h[9:0]) * (2.0 ** (-24));
        else        v = (1.0 + real'(h[9:0]) / 1024.0) * (2.0 ** (e - 15));
        r = to_sgl(v);
        r[31] = h[15];
        return r;
    endfunction

    function automatic logic [31:0] byte_ref(logic [7:0] b, logic f);
        if (!f) return {24'h0, b};
        if (b == 0) return 32'h0;
        return to_sgl(real'(b) / 255.0);
    endfunction

    function automatic logic [31:0] model(logic [31:0] w, logic [2:0] s, logic f);
        case (s)
            3'd0: return w;
            3'd1: return f ? half_ref(w[15:0])  : {{16{w[15]}}, w[15:0]};
            3'd2: return f ? half_ref(w[31:16]) : {{16{w[31]}}, w[31:16]};
            3'd3: return {4{w[31:24]}};
            default: return byte_ref(w[8*(s-4) +: 8], f);
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // driver: one operand per cycle, expected value queued in issue order
    task automatic drive(logic [31:0] w, logic [2:0] s, logic f, string tag);
        item_t it;
        @(negedge clk);
        src_word = w;
        unpk_sel = s;
        as_float = f;
        it.exp = model(w, s, f);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drive_exp(logic [31:0] w, logic [2:0] s, logic f, logic [31:0] e, string tag);
        item_t it;
        @(negedge clk);
        src_word = w;
        unpk_sel = s;
        as_float = f;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: result of the previous cycle's operand appears after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, res_word, it.exp);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        src_word = 32'hFFFF_FFFF;
        unpk_sel = 3'd0;
        repeat (3) @(negedge clk);
        check("R1 reset", res_word, 32'h0);
        rst_n = 1'b1;

        // R2 pass-through, both float settings, back to back
        drive_exp(32'hDEAD_BEEF, 3'd0, 1'b0, 32'hDEAD_BEEF, "R2 pass int");
        drive_exp(32'hDEAD_BEEF, 3'd0, 1'b1, 32'hDEAD_BEEF, "R2 pass float");
        // R3 replicate top byte
        drive_exp(32'h8012_3456, 3'd3, 1'b1, 32'h8080_8080, "R3 repl float");
        drive_exp(32'h7A00_00FF, 3'd3, 1'b0, 32'h7A7A_7A7A, "R3 repl int");
        // R4 integer halves
        drive_exp(32'h7FFF_8001, 3'd1, 1'b0, 32'hFFFF_8001, "R4 low half sext");
        drive_exp(32'h7FFF_8001, 3'd2, 1'b0, 32'h0000_7FFF, "R4 high half");
        // R5 normal halves
        drive_exp(32'h0000_3C00, 3'd1, 1'b1, 32'h3F80_0000, "R5 one");
        drive_exp(32'hC000_0000, 3'd2, 1'b1, 32'hC000_0000, "R5 minus two");
        drive_exp(32'h0000_7BFF, 3'd1, 1'b1, 32'h477F_E000, "R5 max half");
        drive(32'h3555_0400, 3'd1, 1'b1, "R5 min normal");
        drive(32'h3555_0400, 3'd2, 1'b1, "R5 third");
        // R6 specials
        drive_exp(32'h0000_8000, 3'd1, 1'b1, 32'h8000_0000, "R6 neg zero");
        drive_exp(32'h0000_0000, 3'd2, 1'b1, 32'h0000_0000, "R6 pos zero");
        drive_exp(32'h7C00_FC00, 3'd2, 1'b1, 32'h7F80_0000, "R6 pos inf");
        drive_exp(32'h7C00_FC00, 3'd1, 1'b1, 32'hFF80_0000, "R6 neg inf");
        drive_exp(32'h0000_FE01, 3'd1, 1'b1, 32'hFFC0_2000, "R6 nan payload");
        // R7 subnormals
        drive_exp(32'h0000_0001, 3'd1, 1'b1, 32'h3380_0000, "R7 min subnormal");
        drive_exp(32'h83FF_0000, 3'd2, 1'b1, 32'hB87F_C000, "R7 max subnormal neg");
        // R8 integer byte lanes
        drive_exp(32'h1122_3344, 3'd4, 1'b0, 32'h0000_0044, "R8 lane 7:0");
        drive_exp(32'h1122_3344, 3'd5, 1'b0, 32'h0000_0033, "R8 lane 15:8");
        drive_exp(32'h1122_3344, 3'd6, 1'b0, 32'h0000_0022, "R8 lane 23:16");
        drive_exp(32'hF122_3344, 3'd7, 1'b0, 32'h0000_00F1, "R8 lane 31:24");
        // R9 float bytes: ends, then full sweep on two lanes
        drive_exp(32'h0000_0000, 3'd4, 1'b1, 32'h0000_0000, "R9 byte zero");
        drive_exp(32'hFF00_0000, 3'd7, 1'b1, 32'h3F80_0000, "R9 byte full");
        for (int b = 0; b < 256; b++) begin
            drive({8'h5A, 8'(b), 8'hA5, 8'(255 - b)}, 3'd6, 1'b1, "R9 sweep lane 23:16");
            drive({8'h5A, 8'(b), 8'hA5, 8'(255 - b)}, 3'd4, 1'b1, "R9 sweep lane 7:0");
            drive({8'h5A, 8'(b), 8'hA5, 8'(255 - b)}, 3'd6, 1'b0, "R8 sweep int");
        end
        // mixed flips on one word
        for (int k = 0; k < 16; k++) begin
            drive(32'h3C80_9B17 ^ (32'(k) << 9), 3'(k % 8), 1'(k / 8), "R2 R4 R8 mixed");
        end

        @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule